// File: doc/BRIEF.md
# Sequential ADC Scan Sequencer

This block is the digital control for a multiplexed analog-to-digital scan. It holds ten programmable sample slots. Each slot names either one single-ended input or a differential pair of a plus input and a minus input. A start trigger makes the sequencer walk the slots in ascending order. For each slot it drives the multiplexer selection and issues a one-cycle conversion request. It then waits for the converter's ready strobe and stores the 12-bit result in that slot's result register.

A sample disable register holds one bit per slot and bounds the scan. The scan ends at the first slot whose disable bit is set. That slot is not converted, and neither is any later slot, even one that is enabled. Completion is signalled by a sticky end-of-scan flag. The flag stays set until the next start or until software clears it. The slot list, the disable mask, the control bit and the results all sit on a simple synchronous-write, combinational-read register bus.

Top module: `scan_sequencer`

## Requirements
- R1: Slots are converted strictly in ascending order 0, 1, 2 … During each conversion, `mux_pos`, `mux_neg` and `mux_diff` carry the slot's configuration word. Its field layout is: bits 3:0 plus input, bits 7:4 minus input, bit 8 differential flag. The configuration word of slot n is at bus address n (0 to 9).
- R2: The ready strobe's `conv_data` is stored in the result register of the slot being converted. Result n reads at address 16+n, zero-extended to 16 bits.
- R3: The scan ends at the lowest-numbered slot whose disable bit is 1. That slot and all higher slots get no conversion request, and their result registers keep their old contents.
- R4: If the slot-0 disable bit is set, a start produces no conversion request. In that case `scan_done` rises one cycle after the start is sampled.
- R5: After reset, `busy`, `scan_done` and `conv_req` are 0, and the disable register reads 0, so every slot is enabled.
- R6: The disable register is at address 10, with bit n disabling slot n. Bits 15:10 read as 0, and writes to them have no effect.
- R7: A start that is sampled while `busy` is 1 is ignored. The running scan neither restarts nor changes.
- R8: `scan_done` stays 1 until the next accepted start or until a write with bit 0 set to address 11. Either event clears it at the clock edge that samples it.
- R9: A write to the disable register during a scan takes effect when the sequencer examines the next slot's bit.
- R10: `conv_req` is a single-cycle pulse. The multiplexer selection stays stable from the request until the ready strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Scan start trigger, sampled at the rising edge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| mux_pos | output | 4 | Plus-input channel selection |
| mux_neg | output | 4 | Minus-input channel selection |
| mux_diff | output | 1 | 1 selects a differential pair, 0 single-ended |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ready | input | 1 | Conversion result valid strobe |
| conv_data | input | 12 | Conversion result |
| busy | output | 1 | Scan in progress |
| scan_done | output | 1 | Sticky end-of-scan flag |

## Verification
The bench builds the block with its defaults: ten slots, 4-bit channel fields and 12-bit results. These values reach every disable position, including slot 0, slot 9 and a mask with no bit set. The bench's converter model stamps each result with a per-scan tag, so a slot that was skipped keeps a visibly stale value. Because the model answers after a fixed latency, a start and a disable-mask write can both be placed in the middle of a scan.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_REQ   = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_e;

    localparam int unsigned BUS_W     = 16;
    localparam int unsigned ADDR_W    = 5;
    localparam int unsigned RES_BASE  = 16;

endpackage

// File: rtl/scan_cfg_regs.sv
module scan_cfg_regs #(
    parameter int unsigned NUM_SLOTS = 10,
    parameter int unsigned CFG_W     = 9,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned BUS_W     = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [BUS_W-1:0]                wr_data,
    output logic [NUM_SLOTS-1:0][CFG_W-1:0] cfg,
    output logic [NUM_SLOTS-1:0]            dis_mask
);
    localparam int unsigned DIS_ADDR = NUM_SLOTS;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][CFG_W-1:0] cfg;
        logic [NUM_SLOTS-1:0]            dis;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    st_d.cfg[i] = wr_data[CFG_W-1:0];
                end
            end
            if (wr_addr == ADDR_W'(DIS_ADDR)) begin
                st_d.dis = wr_data[NUM_SLOTS-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg      = st_q.cfg;
    assign dis_mask = st_q.dis;
endmodule

// File: rtl/scan_result_bank.sv
module scan_result_bank #(
    parameter int unsigned NUM_SLOTS = 10,
    parameter int unsigned RES_W     = 12,
    parameter int unsigned IDX_W     = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [RES_W-1:0]                wr_data,
    output logic [NUM_SLOTS-1:0][RES_W-1:0] results
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][RES_W-1:0] res;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                st_d.res[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign results = st_q.res;
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_seq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 10,
    parameter int unsigned IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 clr_done,
    input  logic [NUM_SLOTS-1:0] dis_mask,
    input  logic                 conv_ready,
    output logic [IDX_W-1:0]     slot_idx,
    output logic                 conv_req,
    output logic                 res_we,
    output logic                 busy,
    output logic                 scan_done
);
    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic             done;
    } fsm_state_t;

    fsm_state_t st_d, st_q;
    logic       stop_here;

    // The scan ends on the first disabled slot, or after the last slot.
    always_comb begin
        stop_here = (st_q.idx >= IDX_W'(NUM_SLOTS));
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if ((st_q.idx == IDX_W'(i)) && dis_mask[i]) begin
                stop_here = 1'b1;
            end
        end
    end

    always_comb begin
        st_d   = st_q;
        res_we = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.idx   = '0;
                    st_d.done  = 1'b0;
                    st_d.state = ST_CHECK;
                end else if (clr_done) begin
                    st_d.done = 1'b0;
                end
            end
            ST_CHECK: begin
                if (stop_here) begin
                    st_d.done  = 1'b1;
                    st_d.state = ST_IDLE;
                end else begin
                    st_d.state = ST_REQ;
                end
            end
            ST_REQ: begin
                st_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_ready) begin
                    res_we     = 1'b1;
                    st_d.idx   = st_q.idx + IDX_W'(1);
                    st_d.state = ST_CHECK;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, idx: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_idx  = st_q.idx;
    assign conv_req  = (st_q.state == ST_REQ);
    assign busy      = (st_q.state != ST_IDLE);
    assign scan_done = st_q.done;
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 10,
    parameter int unsigned CHAN_W    = 4,
    parameter int unsigned RES_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic [CHAN_W-1:0] mux_pos,
    output logic [CHAN_W-1:0] mux_neg,
    output logic              mux_diff,
    output logic              conv_req,
    input  logic              conv_ready,
    input  logic [RES_W-1:0]  conv_data,
    output logic              busy,
    output logic              scan_done
);
    localparam int unsigned CFG_W     = 2 * CHAN_W + 1;
    localparam int unsigned IDX_W     = $clog2(NUM_SLOTS + 1);
    localparam int unsigned DIS_ADDR  = NUM_SLOTS;
    localparam int unsigned CTRL_ADDR = NUM_SLOTS + 1;

    logic [NUM_SLOTS-1:0][CFG_W-1:0] cfg;
    logic [NUM_SLOTS-1:0]            dis_mask;
    logic [NUM_SLOTS-1:0][RES_W-1:0] results;
    logic [IDX_W-1:0]                slot_idx;
    logic                            res_we;
    logic                            clr_done;
    logic [CFG_W-1:0]                cur_cfg;

    assign clr_done = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR)) && reg_wdata[0];

    scan_cfg_regs #(
        .NUM_SLOTS(NUM_SLOTS), .CFG_W(CFG_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .cfg(cfg), .dis_mask(dis_mask)
    );

    scan_fsm #(
        .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .clr_done(clr_done),
        .dis_mask(dis_mask), .conv_ready(conv_ready), .slot_idx(slot_idx),
        .conv_req(conv_req), .res_we(res_we), .busy(busy), .scan_done(scan_done)
    );

    scan_result_bank #(
        .NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W), .IDX_W(IDX_W)
    ) u_res (
        .clk(clk), .rst_n(rst_n), .wr_en(res_we), .wr_idx(slot_idx),
        .wr_data(conv_data), .results(results)
    );

    // Multiplexer selection follows the slot under conversion.
    always_comb begin
        cur_cfg = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_idx == IDX_W'(i)) begin
                cur_cfg = cfg[i];
            end
        end
    end

    assign mux_pos  = cur_cfg[CHAN_W-1:0];
    assign mux_neg  = cur_cfg[2*CHAN_W-1:CHAN_W];
    assign mux_diff = cur_cfg[CFG_W-1];

    // Register read path; unused and reserved bits read as zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (reg_addr == ADDR_W'(i)) begin
                reg_rdata = BUS_W'(cfg[i]);
            end
            if (reg_addr == ADDR_W'(RES_BASE + i)) begin
                reg_rdata = BUS_W'(results[i]);
            end
        end
        if (reg_addr == ADDR_W'(DIS_ADDR)) begin
            reg_rdata = BUS_W'(dis_mask);
        end
    end
endmodule

// File: rtl/scan_seq_checker.sv
module scan_seq_checker #(
    parameter int unsigned SEL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_req,
    input logic             conv_ready,
    input logic             busy,
    input logic             scan_done,
    input logic [SEL_W-1:0] sel
);
    // R10: request is a single-cycle pulse
    a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R10: selection held from request into the following cycle
    a_r10_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> $stable(sel));

    // R5: no request outside a scan
    a_r5_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !conv_req);

    // R8: end-of-scan flag never set while scanning
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> !busy);

    // R8: flag rises only as a scan finishes
    a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_done) |-> $past(busy));

    // R2: a ready strobe inside a scan is never accepted as a new request cycle
    a_r2_ready_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_ready && busy) |-> !conv_req);
endmodule

bind scan_sequencer scan_seq_checker #(.SEL_W(2 * CHAN_W + 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_ready(conv_ready),
    .busy(busy), .scan_done(scan_done), .sel({mux_diff, mux_neg, mux_pos})
);

// File: tb/tb_scan_sequencer.sv
module tb_scan_sequencer;
    localparam int NSLOT = 10;
    localparam int LAT   = 3;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic        reg_we = 0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  mux_pos, mux_neg;
    logic        mux_diff, conv_req, busy, scan_done;
    logic        conv_ready = 0;
    logic [11:0] conv_data = '0;

    int checks = 0, fails = 0;
    int conv_cnt = 0, base_cnt = 0, order_err = 0, pend = 0;
    logic [3:0]  scan_id = 0;
    logic [11:0] lat_data = '0;

    always #10 clk = ~clk;

    scan_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mux_pos(mux_pos), .mux_neg(mux_neg), .mux_diff(mux_diff),
        .conv_req(conv_req), .conv_ready(conv_ready), .conv_data(conv_data),
        .busy(busy), .scan_done(scan_done)
    );

    // Slot configuration used throughout: plus=n, minus=9-n, diff=odd slot.
    function automatic logic [15:0] cfg_word(int n);
        return {7'd0, 1'(n % 2), 4'(9 - n), 4'(n)};
    endfunction

    // Converter model: checks order (R1), answers LAT cycles after a request.
    always @(posedge clk) begin
        conv_ready <= 1'b0;
        if (conv_req) begin
            if ({mux_diff, mux_neg, mux_pos} != cfg_word(conv_cnt - base_cnt)) order_err <= order_err + 1;
            conv_cnt <= conv_cnt + 1;
            lat_data <= {scan_id, mux_neg, mux_pos};
            pend     <= LAT;
        end else if (pend > 0) begin
            pend <= pend - 1;
            if (pend == 1) begin
                conv_ready <= 1'b1;
                conv_data  <= lat_data;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 300 && !scan_done; i++) @(negedge clk);
    endtask

    // Scan with a given mask and check count, order and result contents.
    task automatic run_scan(logic [15:0] mask, int exp_n);
        logic [15:0] v;
        wr(5'd10, mask);
        scan_id  = scan_id + 1;
        base_cnt = conv_cnt;
        order_err = 0;
        pulse_start();
        wait_done();
        @(negedge clk);
        check("R3 conversion count", conv_cnt - base_cnt, exp_n);
        check("R1 slot order/selection", order_err, 0);
        for (int i = 0; i < NSLOT; i++) begin
            rd(5'(16 + i), v);
            if (i < exp_n) check("R2 stored result", v, {4'd0, scan_id, 4'(9 - i), 4'(i)});
            else check("R3 later slot untouched", v[11:8] == scan_id, 0);
        end
    endtask

    localparam logic [15:0] MASKS [8] = '{16'h0000, 16'h0020, 16'h0200, 16'h0010,
                                         16'h0204, 16'h03FE, 16'h00A0, 16'h0100};
    localparam int EXPN [8] = '{10, 5, 9, 4, 2, 1, 5, 8};

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog R3 actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R5 reset state
        check("R5 busy", busy, 0);
        check("R5 scan_done", scan_done, 0);
        check("R5 conv_req", conv_req, 0);
        rd(5'd10, v);
        check("R5 disable reset", v, 0);

        for (int i = 0; i < NSLOT; i++) wr(5'(i), cfg_word(i));
        rd(5'd3, v);
        check("R1 config readback", v, cfg_word(3));

        // R6 reserved bits
        wr(5'd10, 16'hFFFF);
        rd(5'd10, v);
        check("R6 reserved bits read zero", v, 16'h03FF);

        // Table of masks
        for (int k = 0; k < 8; k++) run_scan(MASKS[k], EXPN[k]);

        // R8 sticky done, software clear
        repeat (20) @(negedge clk);
        check("R8 done sticky", scan_done, 1);
        wr(5'd11, 16'h0001);
        check("R8 done cleared by write", scan_done, 0);

        // R4 slot 0 disabled, done next cycle
        run_scan(16'h0000, 10);
        wr(5'd10, 16'h0001);
        base_cnt = conv_cnt;
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        check("R8 done cleared by start", scan_done, 0);
        check("R4 busy after start", busy, 1);
        @(negedge clk);
        check("R4 done next cycle", scan_done, 1);
        repeat (10) @(negedge clk);
        check("R4 no conversions", conv_cnt - base_cnt, 0);

        // R9 mid-scan disable write
        wr(5'd10, 16'h0000);
        scan_id = scan_id + 1;
        base_cnt = conv_cnt;
        order_err = 0;
        pulse_start();
        for (int i = 0; i < 300 && (conv_cnt - base_cnt) < 3; i++) @(negedge clk);
        wr(5'd10, 16'h0080);
        wait_done();
        @(negedge clk);
        check("R9 mid-scan mask honoured", conv_cnt - base_cnt, 7);

        // R7 start while busy ignored
        wr(5'd10, 16'h0000);
        scan_id = scan_id + 1;
        base_cnt = conv_cnt;
        order_err = 0;
        pulse_start();
        for (int i = 0; i < 300 && (conv_cnt - base_cnt) < 3; i++) @(negedge clk);
        pulse_start();
        wait_done();
        @(negedge clk);
        check("R7 no restart count", conv_cnt - base_cnt, 10);
        check("R7 no restart order", order_err, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule